// File: doc/BRIEF.md
# Serial Receiver with Sync Hunt and Break Detection

This block turns a serial input line into parallel characters. It works in one of two modes. In start/stop (asynchronous) mode it oversamples the line, confirms each start bit, and checks the parity and stop bits. It also flags a break when the line stays at space across the stop positions of two frames in a row.

In synchronous mode it samples one bit per receive-clock tick. It then reaches character alignment in one of two ways:
- It slides a window over the incoming bits until the window matches one or two programmed sync characters.
- It takes a high level on an external sync input as the start of character assembly.

Each finished character goes into a holding register. The holding register has a ready flag and sticky parity, overrun and framing error flags.

The receive clock arrives as a one-cycle enable, `rx_tick`, in the system clock domain. Bus decoding is not part of this block. The read and command strobes arrive as one-cycle pulses. The shared detect pin is a split output, output-enable and input set. In asynchronous mode and internal synchronous mode it drives break or sync-detect status. In external synchronous mode it becomes an input.

Top module: `serial_rx_hunt`

## Requirements
- R1: A completed character sets `rx_rdy` on the next clock and loads `rx_data`. Data arrives LSB first. Bits above the character length read 0. A `rd_data` pulse clears `rx_rdy`.
- R2: If a character completes while `rx_rdy` is still set and no `rd_data` arrives in the same cycle, the new character replaces the old one and `ovr_err` is set.
- R3: In asynchronous mode the oversampling factor is 16 when `baud_x64`=0 and 64 when `baud_x64`=1. A falling edge starts a frame only if the line is still low half a bit later. A low pulse shorter than half a bit produces no character. Each later bit is sampled one bit time after the previous sample.
- R4: `par_en`=1 adds a parity bit after the data bits, in both modes. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A wrong parity bit sets `par_err`.
- R5: In asynchronous mode a stop bit sampled low sets `frm_err`.
- R6: In asynchronous mode `det_out` goes high once two frames in a row end with all data bits, the parity bit and the stop bit sampled low.
- R7: In asynchronous mode the break indication clears on the clock after a receive tick that samples `rxd` high.
- R8: In internal synchronous mode (`mode_sync`=1, `ext_sync`=0, `dbl_sync`=0), the block compares the most recent character-length bits with `sync_pat1` after every bit. A match sets `det_out` high, and the following bits are assembled into characters.
- R9: With `dbl_sync`=1, a match with `sync_pat1` must be followed at once by a character equal to `sync_pat2` before `det_out` rises. On a mismatch the block returns to bit-by-bit hunting.
- R10: A `rd_status` pulse clears the sync-detect indication. A new sync match in the same cycle wins.
- R11: In external synchronous mode `det_oe` is 0. Nothing is assembled while `det_in` is low. A tick with `det_in` high starts assembly, and the first data bit is taken on the next tick.
- R12: An `err_rst` pulse clears `par_err`, `ovr_err` and `frm_err`. An error raised in the same cycle wins.
- R13: After reset `det_out`, `rx_rdy` and all three error flags are 0. The character length is 5 + `len_code` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | One-cycle receive clock enable |
| rxd | input | 1 | Serial data line |
| mode_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| ext_sync | input | 1 | In synchronous mode, take alignment from `det_in` |
| dbl_sync | input | 1 | Hunt for two sync characters |
| len_code | input | 2 | Character length minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when set |
| baud_x64 | input | 1 | Asynchronous oversampling: 0 = x16, 1 = x64 |
| sync_pat1 | input | 8 | First sync character |
| sync_pat2 | input | 8 | Second sync character |
| hunt_cmd | input | 1 | Pulse: restart hunting |
| err_rst | input | 1 | Pulse: clear error flags |
| rd_data | input | 1 | Pulse: character read |
| rd_status | input | 1 | Pulse: status read, clears sync detect |
| det_in | input | 1 | External sync level (detect pin as input) |
| rx_data | output | 8 | Holding register |
| rx_rdy | output | 1 | Character waiting |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |
| det_out | output | 1 | Break (async) or sync detect (sync) |
| det_oe | output | 1 | Detect pin drive enable |

## Verification
A bit timer that loses count shows up at the ports within one frame. The shifted data comes out rotated, or the ready flag never rises, and either one is seen on the first character after the fault. A hunt window that is misaligned, or the wrong length, raises the detect output one bit early or late. It can also raise it on the wrong pattern, and the next character then arrives with its bits shifted. A holding register that applies its set and clear in the wrong priority order shows a stale ready flag, or overrun and error flags that do not stick, at the check right after the second character or after the clear pulse.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver: framer state encodings.
package srx_pkg;
    typedef enum logic [2:0] {
        A_IDLE,
        A_START,
        A_DATA,
        A_PAR,
        A_STOP
    } async_st_t;

    typedef enum logic [1:0] {
        S_HUNT,
        S_HUNT2,
        S_RUN
    } sync_st_t;
endpackage

// File: rtl/srx_async_frm.sv
// Start/stop framer. It oversamples rxd on rx_tick and confirms the start bit
// at half a bit. It samples the data, parity and stop bits at their centres
// and tracks break. Assumes the mode inputs are static between resets.
module srx_async_frm #(
    parameter int DW  = 8,
    parameter int FLO = 16,
    parameter int FHI = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          rxd,
    input  logic [1:0]    len_code,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          x64,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          pe,
    output logic          fe,
    output logic          brk
);
    import srx_pkg::*;

    localparam int CW = $clog2(FHI) + 1;

    async_st_t     st;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          prev_zero;
    logic [3:0]    len;
    logic [3:0]    shamt;
    logic [CW-1:0] full;
    logic [CW-1:0] half;
    logic [DW-1:0] algn;
    logic          zero_frm;

    // Derive the frame geometry from the mode inputs.
    always_comb begin
        len      = 4'(DW - 3) + {2'b00, len_code};
        shamt    = 4'(DW) - len;
        full     = x64 ? CW'(FHI) : CW'(FLO);
        half     = full >> 1;
        algn     = sh >> shamt;
        zero_frm = (algn == '0) && !(par_en && pbit) && !rxd;
    end

    // Bit timing, shifting and end-of-frame reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= A_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            sh        <= '0;
            pbit      <= 1'b0;
            prev_zero <= 1'b0;
            done      <= 1'b0;
            data      <= '0;
            pe        <= 1'b0;
            fe        <= 1'b0;
            brk       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st        <= A_IDLE;
                brk       <= 1'b0;
                prev_zero <= 1'b0;
            end else if (tick) begin
                if (rxd) begin
                    brk <= 1'b0;
                end
                case (st)
                    A_IDLE: begin
                        if (!rxd) begin
                            st  <= A_START;
                            cnt <= CW'(1);
                        end
                    end
                    A_START: begin
                        if (cnt == half) begin
                            if (!rxd) begin
                                st   <= A_DATA;
                                cnt  <= CW'(1);
                                bidx <= '0;
                                sh   <= '0;
                            end else begin
                                st <= A_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    A_DATA: begin
                        if (cnt == full) begin
                            cnt  <= CW'(1);
                            sh   <= {rxd, sh[DW-1:1]};
                            bidx <= bidx + 4'd1;
                            if (bidx == len - 4'd1) begin
                                st <= par_en ? A_PAR : A_STOP;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    A_PAR: begin
                        if (cnt == full) begin
                            cnt  <= CW'(1);
                            pbit <= rxd;
                            st   <= A_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    A_STOP: begin
                        if (cnt == full) begin
                            st        <= A_IDLE;
                            done      <= 1'b1;
                            data      <= algn;
                            fe        <= !rxd;
                            pe        <= par_en && ((^algn) ^ pbit ^ par_odd);
                            prev_zero <= zero_frm;
                            if (zero_frm && prev_zero) begin
                                brk <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: st <= A_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_sync_frm.sv
// Synchronous framer: one bit per rx_tick. It hunts for one or two sync
// characters through a sliding window, or starts on the external sync level,
// and then assembles characters. Assumes the mode inputs are static.
module srx_sync_frm #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          rxd,
    input  logic          ext,
    input  logic          dbl,
    input  logic [1:0]    len_code,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic [DW-1:0] pat1,
    input  logic [DW-1:0] pat2,
    input  logic          hunt,
    input  logic          ext_in,
    input  logic          rd_status,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          pe,
    output logic          hit,
    output logic          syndet
);
    import srx_pkg::*;

    sync_st_t      st;
    logic [DW-1:0] sh;
    logic [DW-1:0] shn;
    logic [3:0]    bidx;
    logic [3:0]    len;
    logic [3:0]    shamt;
    logic [DW-1:0] mask;
    logic [DW-1:0] win;
    logic [DW-1:0] algn;
    logic          last;

    // Window and character-boundary decode.
    always_comb begin
        len   = 4'(DW - 3) + {2'b00, len_code};
        shamt = 4'(DW) - len;
        mask  = {DW{1'b1}} >> shamt;
        shn   = {rxd, sh[DW-1:1]};
        win   = shn >> shamt;
        algn  = sh >> shamt;
        last  = bidx == (len - 4'd1 + {3'b000, par_en});
    end

    // Hunt and assembly sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_HUNT;
            sh     <= '0;
            bidx   <= '0;
            done   <= 1'b0;
            data   <= '0;
            pe     <= 1'b0;
            hit    <= 1'b0;
            syndet <= 1'b0;
        end else begin
            done <= 1'b0;
            hit  <= 1'b0;
            if (!en) begin
                st     <= S_HUNT;
                syndet <= 1'b0;
            end else begin
                if (rd_status) begin
                    syndet <= 1'b0;
                end
                if (hunt) begin
                    st <= S_HUNT;
                end else if (tick) begin
                    case (st)
                        S_HUNT: begin
                            sh <= shn;
                            if (ext) begin
                                if (ext_in) begin
                                    st   <= S_RUN;
                                    bidx <= '0;
                                end
                            end else if (win == (pat1 & mask)) begin
                                bidx <= '0;
                                if (dbl) begin
                                    st <= S_HUNT2;
                                end else begin
                                    st     <= S_RUN;
                                    syndet <= 1'b1;
                                    hit    <= 1'b1;
                                end
                            end
                        end
                        S_HUNT2: begin
                            sh   <= shn;
                            bidx <= bidx + 4'd1;
                            if (bidx == len - 4'd1) begin
                                if (win == (pat2 & mask)) begin
                                    st     <= S_RUN;
                                    bidx   <= '0;
                                    syndet <= 1'b1;
                                    hit    <= 1'b1;
                                end else begin
                                    st <= S_HUNT;
                                end
                            end
                        end
                        S_RUN: begin
                            if (bidx < len) begin
                                sh <= shn;
                            end
                            if (last) begin
                                bidx <= '0;
                                done <= 1'b1;
                                if (par_en) begin
                                    data <= algn;
                                    pe   <= (^algn) ^ rxd ^ par_odd;
                                end else begin
                                    data <= win;
                                    pe   <= 1'b0;
                                end
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end
                        default: st <= S_HUNT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/srx_hold.sv
// Holding register with a ready flag and sticky error flags. A set in the
// same cycle beats a clear; a read in the same cycle as a new character
// prevents overrun.
module srx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] din,
    input  logic          pe_in,
    input  logic          fe_in,
    input  logic          rd_data,
    input  logic          err_rst,
    output logic [DW-1:0] rx_data,
    output logic          rx_rdy,
    output logic          par_err,
    output logic          ovr_err,
    output logic          frm_err
);
    // Load characters, track ready and accumulate errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_rdy  <= 1'b0;
            par_err <= 1'b0;
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            if (err_rst) begin
                par_err <= 1'b0;
                ovr_err <= 1'b0;
                frm_err <= 1'b0;
            end
            if (rd_data) begin
                rx_rdy <= 1'b0;
            end
            if (done) begin
                rx_data <= din;
                rx_rdy  <= 1'b1;
                if (rx_rdy && !rd_data) begin
                    ovr_err <= 1'b1;
                end
                if (pe_in) begin
                    par_err <= 1'b1;
                end
                if (fe_in) begin
                    frm_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_hunt.sv
// Top of the serial receiver. It picks the framer by mode, feeds the holding
// register and steers the shared detect pin. Assumes the mode inputs change
// only while reset is held.
module serial_rx_hunt #(
    parameter int DW  = 8,
    parameter int FLO = 16,
    parameter int FHI = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_tick,
    input  logic          rxd,
    input  logic          mode_sync,
    input  logic          ext_sync,
    input  logic          dbl_sync,
    input  logic [1:0]    len_code,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          baud_x64,
    input  logic [DW-1:0] sync_pat1,
    input  logic [DW-1:0] sync_pat2,
    input  logic          hunt_cmd,
    input  logic          err_rst,
    input  logic          rd_data,
    input  logic          rd_status,
    input  logic          det_in,
    output logic [DW-1:0] rx_data,
    output logic          rx_rdy,
    output logic          par_err,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          det_out,
    output logic          det_oe
);
    logic          a_done, a_pe, a_fe, a_brk;
    logic [DW-1:0] a_data;
    logic          s_done, s_pe, s_syndet;
    logic [DW-1:0] s_data;
    logic          sync_hit;
    logic          char_done;
    logic [DW-1:0] char_data;
    logic          char_pe, char_fe;

    srx_async_frm #(.DW(DW), .FLO(FLO), .FHI(FHI)) async_i (
        .clk(clk), .rst_n(rst_n), .en(!mode_sync), .tick(rx_tick), .rxd(rxd),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd), .x64(baud_x64),
        .done(a_done), .data(a_data), .pe(a_pe), .fe(a_fe), .brk(a_brk)
    );

    srx_sync_frm #(.DW(DW)) sync_i (
        .clk(clk), .rst_n(rst_n), .en(mode_sync), .tick(rx_tick), .rxd(rxd),
        .ext(ext_sync), .dbl(dbl_sync), .len_code(len_code), .par_en(par_en),
        .par_odd(par_odd), .pat1(sync_pat1), .pat2(sync_pat2), .hunt(hunt_cmd),
        .ext_in(det_in), .rd_status(rd_status), .done(s_done), .data(s_data),
        .pe(s_pe), .hit(sync_hit), .syndet(s_syndet)
    );

    // Route the active framer to the holding register.
    always_comb begin
        char_done = mode_sync ? s_done : a_done;
        char_data = mode_sync ? s_data : a_data;
        char_pe   = mode_sync ? s_pe   : a_pe;
        char_fe   = mode_sync ? 1'b0   : a_fe;
    end

    srx_hold #(.DW(DW)) hold_i (
        .clk(clk), .rst_n(rst_n), .done(char_done), .din(char_data),
        .pe_in(char_pe), .fe_in(char_fe), .rd_data(rd_data), .err_rst(err_rst),
        .rx_data(rx_data), .rx_rdy(rx_rdy), .par_err(par_err),
        .ovr_err(ovr_err), .frm_err(frm_err)
    );

    // Detect pin: break status, sync status, or released as an input.
    always_comb begin
        det_out = mode_sync ? s_syndet : a_brk;
        det_oe  = !(mode_sync && ext_sync);
    end
endmodule

// File: rtl/srx_checker.sv
// Temporal checks for serial_rx_hunt, attached by bind.
module srx_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_sync,
    input logic ext_sync,
    input logic rx_tick,
    input logic rxd,
    input logic rd_data,
    input logic rd_status,
    input logic err_rst,
    input logic char_done,
    input logic sync_hit,
    input logic rx_rdy,
    input logic par_err,
    input logic ovr_err,
    input logic frm_err,
    input logic det_out
);
    AST_RDY_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_rdy); // R1
    AST_RDY_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !char_done |=> !rx_rdy); // R1
    AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && rx_rdy && !rd_data |=> ovr_err); // R2
    AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sync && rx_tick && rxd |=> !det_out); // R7
    AST_SYNDET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sync && !ext_sync && rd_status |=> (!det_out || sync_hit)); // R10
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        err_rst && !char_done |=> !par_err && !ovr_err && !frm_err); // R12
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !det_out && !rx_rdy && !ovr_err); // R13
endmodule

bind serial_rx_hunt srx_checker chk_i (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .ext_sync(ext_sync),
    .rx_tick(rx_tick), .rxd(rxd), .rd_data(rd_data), .rd_status(rd_status),
    .err_rst(err_rst), .char_done(char_done), .sync_hit(sync_hit),
    .rx_rdy(rx_rdy), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .det_out(det_out)
);

// File: tb/serial_rx_hunt_tb_top.sv
// Bench: drives inputs on falling edges and keeps a behavioural model of the
// holding register and the pin direction. The model is checked each clock
// (direction) and after every stimulus step (data and flags).
module serial_rx_hunt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0, rxd = 1'b1;
    logic       mode_sync = 1'b0, ext_sync = 1'b0, dbl_sync = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       par_en = 1'b0, par_odd = 1'b0, baud_x64 = 1'b0;
    logic [7:0] sync_pat1 = 8'h16, sync_pat2 = 8'h3C;
    logic       hunt_cmd = 1'b0, err_rst = 1'b0, rd_data = 1'b0, rd_status = 1'b0;
    logic       det_in = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, par_err, ovr_err, frm_err, det_out, det_oe;

    int  nchk = 0;
    int  nfail = 0;
    bit  fin = 1'b0;

    // Model state.
    logic [7:0] m_data = '0;
    bit m_rdy = 0, m_pe = 0, m_fe = 0, m_ovr = 0;

    always #10 clk = ~clk;

    serial_rx_hunt dut_i (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd),
        .mode_sync(mode_sync), .ext_sync(ext_sync), .dbl_sync(dbl_sync),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
        .baud_x64(baud_x64), .sync_pat1(sync_pat1), .sync_pat2(sync_pat2),
        .hunt_cmd(hunt_cmd), .err_rst(err_rst), .rd_data(rd_data),
        .rd_status(rd_status), .det_in(det_in), .rx_data(rx_data),
        .rx_rdy(rx_rdy), .par_err(par_err), .ovr_err(ovr_err),
        .frm_err(frm_err), .det_out(det_out), .det_oe(det_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pin direction compared on every clock (R11).
    always @(negedge clk) begin
        if (rst_n && !fin) check("R11 det_oe", {31'd0, det_oe}, {31'd0, !(mode_sync && ext_sync)});
    end

    task automatic cmp_all(string req);
        check({req, " rx_rdy"}, {31'd0, rx_rdy}, {31'd0, m_rdy});
        check({req, " rx_data"}, {24'd0, rx_data}, {24'd0, m_data});
        check({req, " par_err"}, {31'd0, par_err}, {31'd0, m_pe});
        check({req, " frm_err"}, {31'd0, frm_err}, {31'd0, m_fe});
        check({req, " ovr_err"}, {31'd0, ovr_err}, {31'd0, m_ovr});
    endtask

    task automatic m_char(logic [7:0] d, bit pe, bit fe);
        if (m_rdy) m_ovr = 1;
        m_data = d; m_rdy = 1;
        if (pe) m_pe = 1;
        if (fe) m_fe = 1;
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) begin
            rx_tick = 1'b1; @(negedge clk);
            rx_tick = 1'b0; @(negedge clk); @(negedge clk);
        end
    endtask

    task automatic pulse_rd();
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; m_rdy = 0;
    endtask

    task automatic pulse_err();
        err_rst = 1'b1; @(negedge clk); err_rst = 1'b0; m_pe = 0; m_fe = 0; m_ovr = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
        m_data = '0; m_rdy = 0; m_pe = 0; m_fe = 0; m_ovr = 0;
    endtask

    function automatic bit par_of(logic [7:0] d, int len, bit odd);
        bit p = odd;
        for (int i = 0; i < len; i++) p ^= d[i];
        return p;
    endfunction

    // One asynchronous frame; bad flips parity, stop gives the stop level.
    task automatic async_frame(logic [7:0] d, bit bad, bit stop);
        int f = baud_x64 ? 64 : 16;
        int len = 5 + int'(len_code);
        rxd = 1'b0; tk(f);
        for (int i = 0; i < len; i++) begin rxd = d[i]; tk(f); end
        if (par_en) begin rxd = par_of(d, len, par_odd) ^ bad; tk(f); end
        rxd = stop; tk(f);
        rxd = 1'b1; tk(f);
    endtask

    task automatic sbits(logic [7:0] d, int n);
        for (int i = 0; i < n; i++) begin rxd = d[i]; tk(1); end
    endtask

    initial begin
        do_reset();
        // Reset state
        cmp_all("R13 reset");
        check("R13 det_out", {31'd0, det_out}, 32'd0);

        // Plain 8-bit frame at x16
        async_frame(8'hA5, 0, 1); m_char(8'hA5, 0, 0); cmp_all("R1 async char");
        pulse_rd(); cmp_all("R1 read clears");

        // Short low glitch
        rxd = 1'b0; tk(4); rxd = 1'b1; tk(40); cmp_all("R3 glitch ignored");

        // 7 bits, odd parity: good then bad
        len_code = 2'd2; par_en = 1'b1; par_odd = 1'b1;
        async_frame(8'h55, 0, 1); m_char(8'h55, 0, 0); cmp_all("R4 good odd parity");
        pulse_rd();
        async_frame(8'h2A, 1, 1); m_char(8'h2A, 1, 0); cmp_all("R4 bad parity");
        // Unread previous: overrun
        async_frame(8'h11, 0, 1); m_char(8'h11, 0, 0); cmp_all("R2 overrun");
        pulse_err(); cmp_all("R12 error reset");
        pulse_rd();

        // Framing error, 8 bits no parity
        len_code = 2'd3; par_en = 1'b0; par_odd = 1'b0;
        async_frame(8'h0F, 0, 0); m_char(8'h0F, 0, 1); cmp_all("R5 framing");
        check("R6 no break on nonzero", {31'd0, det_out}, 32'd0);
        pulse_err(); pulse_rd();

        // 5-bit even parity character at x64
        baud_x64 = 1'b1; len_code = 2'd0; par_en = 1'b1;
        async_frame(8'h1C, 0, 1); m_char(8'h1C, 0, 0); cmp_all("R3 x64 5-bit R13");
        baud_x64 = 1'b0; len_code = 2'd3; par_en = 1'b0;

        // Break
        do_reset();
        rxd = 1'b0; tk(25 * 16);
        check("R6 break set", {31'd0, det_out}, 32'd1);
        check("R5 break framing", {31'd0, frm_err}, 32'd1);
        rxd = 1'b1; tk(1);
        check("R7 break cleared", {31'd0, det_out}, 32'd0);
        tk(200);

        // Internal single sync
        rst_n = 1'b0; mode_sync = 1'b1; do_reset();
        sbits(8'hFF, 8);
        check("R8 no early detect", {31'd0, det_out}, 32'd0);
        sbits(8'h16, 8);
        check("R8 sync detect", {31'd0, det_out}, 32'd1);
        sbits(8'hA5, 8); m_char(8'hA5, 0, 0); cmp_all("R8 char after sync");
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        check("R10 status read clears", {31'd0, det_out}, 32'd0);

        // Double sync
        rst_n = 1'b0; dbl_sync = 1'b1; do_reset();
        sbits(8'hFF, 8); sbits(8'h16, 8); sbits(8'hFF, 8);
        check("R9 second mismatch", {31'd0, det_out}, 32'd0);
        sbits(8'h16, 8);
        check("R9 first only", {31'd0, det_out}, 32'd0);
        sbits(8'h3C, 8);
        check("R9 both matched", {31'd0, det_out}, 32'd1);
        sbits(8'h5A, 8); m_char(8'h5A, 0, 0); cmp_all("R9 char after double sync");
        hunt_cmd = 1'b1; @(negedge clk); hunt_cmd = 1'b0;

        // External sync with even parity
        rst_n = 1'b0; dbl_sync = 1'b0; ext_sync = 1'b1; par_en = 1'b1; do_reset();
        check("R11 pin released", {31'd0, det_oe}, 32'd0);
        sbits(8'h00, 8); sbits(8'h00, 8);
        cmp_all("R11 idle without sync");
        det_in = 1'b1; tk(1); det_in = 1'b0;
        sbits(8'h81, 8); sbits(8'h00, 1); m_char(8'h81, 0, 0); cmp_all("R11 external start");
        sbits(8'h81, 8); sbits(8'h01, 1); m_char(8'h81, 1, 0); cmp_all("R4 sync parity R2");

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule